// File: doc/BRIEF.md
# CAN Receive Record FIFO

This block is the receive store of a CAN controller. Frames that have already passed acceptance arrive on a parallel frame port. Each frame holds the extended and remote flags, the DLC, a 29-bit identifier and up to eight data bytes. The block turns each frame into a packed variable-length byte record and writes it into a circular byte buffer, one byte per clock. While a record is being written, `in_ready_o` is low, which holds the next frame off.

The processor side sees the oldest stored record through a byte window. Offset `k` returns the buffer byte `k` places after the start pointer. A one-cycle release pulse discards the oldest record. The length of that record is decoded from its own stored header byte.

The block keeps a byte count and a message count. It drives a receive-pending flag and a receiving-busy flag. It sets a sticky overrun flag when a whole record would not fit, and in that case the frame is dropped entirely. A pulse on entry to operating mode empties the store.

Top module: `canrx_record_fifo`

## Requirements
- R1: After reset, the byte count and message count are 0, overrun, pending and busy are 0, and `in_ready_o` is 1.
- R2: An extended frame is stored in this byte order:
  - the header, whose bit 7 is the extended flag, bit 6 is the remote flag, bits 5:4 are 0 and bits 3:0 are the DLC;
  - ID[28:21], ID[20:13] and ID[12:5];
  - ID[4:0] in bits 7:3 with bits 2:0 zero;
  - the data bytes, byte 0 first.
  Its length is 5 plus the DLC.
- R3: A standard frame is stored in this byte order:
  - the header;
  - ID[10:3];
  - ID[2:0] in bits 7:5 with bits 4:0 zero;
  - the data bytes.
  Its length is 3 plus the DLC.
- R4: A remote frame stores its header and identifier bytes only (3 or 5 bytes), and its header still keeps its DLC. Its release removes the same number of bytes.
- R5: A frame with the error flag set, or with a DLC above 8, is not stored, and the counts and the overrun flag do not change.
- R6: If the byte count plus the new record length exceeds 64, the whole frame is dropped, the counts do not change and the overrun flag sets. The overrun flag stays set until an overrun-clear pulse.
- R7: A release pulse while messages are stored advances the start pointer, modulo 64, by the length decoded from the oldest header: 3, plus 2 if the record is extended, plus the DLC if it is not remote. The byte count drops by that length and the message count drops by one. A release with no message stored changes nothing.
- R8: Receive-pending is 1 exactly while the message count is non-zero.
- R9: The window at offset k, from 0 to 12, returns buffer[(start + k) mod 64].
- R10: Busy rises in the cycle after a frame is taken and falls when the frame is stored, rejected or dropped for overrun.
  - `in_ready_o` is low while busy.
  - A rejected or dropped frame takes 1 cycle after the handshake.
  - A stored frame takes 1 plus its length, and the counts update with its last byte.
- R11: An operating-mode entry pulse clears both counts, aborts a record being written and empties the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Frame present on the frame port |
| in_ready_o | output | 1 | Block can take a frame |
| in_ext_i | input | 1 | Extended identifier flag |
| in_rtr_i | input | 1 | Remote frame flag |
| in_err_i | input | 1 | Error frame marker |
| in_dlc_i | input | 4 | Data length code |
| in_id_i | input | 29 | Identifier, standard IDs in bits 10:0 |
| in_data_i | input | 64 | Data, byte 0 in bits 7:0 |
| rel_i | input | 1 | Release the oldest record |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| op_enter_i | input | 1 | Entry to operating mode, empties the store |
| win_off_i | input | 4 | Window byte offset |
| win_data_o | output | 8 | Byte at start plus offset |
| byte_count_o | output | 7 | Stored byte count |
| msg_count_o | output | 7 | Stored message count |
| rx_pending_o | output | 1 | At least one message stored |
| overrun_o | output | 1 | Sticky overrun flag |
| rx_busy_o | output | 1 | Frame being processed |

## Verification
The embedded properties check the following on every cycle:
- the byte count never exceeds the buffer;
- no bytes are counted while no message is stored;
- a release on an empty store leaves the start pointer where it was;
- ready is low while busy;
- a drop for overrun leaves the byte count unchanged.

Only the bench scenarios can show the exact record byte layouts, the length decoded on release for remote and extended records, wrap-around of the window across the end of the buffer, and the handshake-to-commit cycle counts. Random traffic checks these against a bench model of the byte queue, while directed steps hit rejection, a fill to overrun and mode entry.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
    localparam int MAX_DLC   = 8;
    localparam int REC_LEN_W = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WRITE} fill_st_e;

    typedef struct packed {
        logic        ext;
        logic        rtr;
        logic        err;
        logic [3:0]  dlc;
        logic [28:0] id;
        logic [63:0] data;
    } frame_t;
endpackage

// File: rtl/canrx_rec_len.sv
module canrx_rec_len
    import canrx_pkg::*;
(
    input  logic [7:0]           info_i,
    output logic [REC_LEN_W-1:0] len_o
);
    // record length from a header byte: 3, +2 extended, +DLC unless remote
    always_comb begin
        len_o = REC_LEN_W'(3);
        if (info_i[7]) len_o = len_o + REC_LEN_W'(2);
        if (!info_i[6]) len_o = len_o + REC_LEN_W'(info_i[3:0]);
    end
endmodule

// File: rtl/canrx_byte_ram.sv
module canrx_byte_ram #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_a_i,
    output logic [7:0]        rdata_a_o,
    input  logic [ADDR_W-1:0] raddr_b_i,
    output logic [7:0]        rdata_b_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/canrx_record_fifo.sv
module canrx_record_fifo
    import canrx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid_i,
    output logic        in_ready_o,
    input  logic        in_ext_i,
    input  logic        in_rtr_i,
    input  logic        in_err_i,
    input  logic [3:0]  in_dlc_i,
    input  logic [28:0] in_id_i,
    input  logic [63:0] in_data_i,
    input  logic        rel_i,
    input  logic        ovr_clr_i,
    input  logic        op_enter_i,
    input  logic [3:0]  win_off_i,
    output logic [7:0]  win_data_o,
    output logic [6:0]  byte_count_o,
    output logic [6:0]  msg_count_o,
    output logic        rx_pending_o,
    output logic        overrun_o,
    output logic        rx_busy_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        fill_st_e             st;
        logic [AW-1:0]        wr_ptr;
        logic [AW-1:0]        rd_ptr;
        logic [CW-1:0]        byte_cnt;
        logic [CW-1:0]        msg_cnt;
        logic [REC_LEN_W-1:0] idx;
        logic [REC_LEN_W-1:0] len;
        frame_t               frm;
        logic                 ovr;
        logic                 busy;
    } state_t;

    state_t s_d, s_q;

    logic                 we;
    logic [7:0]           wdata;
    logic [7:0]           rel_info;
    logic [REC_LEN_W-1:0] rel_len;
    logic [REC_LEN_W-1:0] cap_len;
    logic [7:0]           cap_info;

    function automatic logic [7:0] rec_byte(frame_t f, logic [REC_LEN_W-1:0] idx);
        logic [REC_LEN_W-1:0] di;
        logic [63:0]          sh;
        di = f.ext ? idx - REC_LEN_W'(5) : idx - REC_LEN_W'(3);
        sh = f.data >> {di, 3'b000};
        if (idx == '0) return {f.ext, f.rtr, 2'b00, f.dlc};
        if (f.ext) begin
            case (idx)
                REC_LEN_W'(1): return f.id[28:21];
                REC_LEN_W'(2): return f.id[20:13];
                REC_LEN_W'(3): return f.id[12:5];
                REC_LEN_W'(4): return {f.id[4:0], 3'b000};
                default:       return sh[7:0];
            endcase
        end
        case (idx)
            REC_LEN_W'(1): return f.id[10:3];
            REC_LEN_W'(2): return {f.id[2:0], 5'b00000};
            default:       return sh[7:0];
        endcase
    endfunction

    assign cap_info = {s_q.frm.ext, s_q.frm.rtr, 2'b00, s_q.frm.dlc};

    canrx_rec_len u_cap_len (.info_i(cap_info), .len_o(cap_len));
    canrx_rec_len u_rel_len (.info_i(rel_info), .len_o(rel_len));

    canrx_byte_ram #(.DEPTH(DEPTH), .ADDR_W(AW)) u_ram (
        .clk       (clk),
        .we_i      (we),
        .waddr_i   (s_q.wr_ptr),
        .wdata_i   (wdata),
        .raddr_a_i (s_q.rd_ptr),
        .rdata_a_o (rel_info),
        .raddr_b_i (s_q.rd_ptr + AW'(win_off_i)),
        .rdata_b_o (win_data_o)
    );

    always_comb begin
        s_d   = s_q;
        we    = 1'b0;
        wdata = rec_byte(s_q.frm, s_q.idx);
        if (ovr_clr_i) s_d.ovr = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (in_valid_i) begin
                    s_d.frm  = '{ext: in_ext_i, rtr: in_rtr_i, err: in_err_i,
                                 dlc: in_dlc_i, id: in_id_i, data: in_data_i};
                    s_d.st   = ST_CHECK;
                    s_d.busy = 1'b1;
                end
            end
            ST_CHECK: begin
                if (s_q.frm.err || (s_q.frm.dlc > 4'(MAX_DLC))) begin
                    s_d.st   = ST_IDLE;
                    s_d.busy = 1'b0;
                end else if (({1'b0, s_q.byte_cnt} + (CW+1)'(cap_len)) > (CW+1)'(DEPTH)) begin
                    s_d.ovr  = 1'b1;
                    s_d.st   = ST_IDLE;
                    s_d.busy = 1'b0;
                end else begin
                    s_d.st  = ST_WRITE;
                    s_d.idx = '0;
                    s_d.len = cap_len;
                end
            end
            ST_WRITE: begin
                we         = 1'b1;
                s_d.wr_ptr = s_q.wr_ptr + AW'(1);
                s_d.idx    = s_q.idx + REC_LEN_W'(1);
                if (s_q.idx == s_q.len - REC_LEN_W'(1)) begin
                    s_d.st       = ST_IDLE;
                    s_d.busy     = 1'b0;
                    s_d.byte_cnt = s_q.byte_cnt + CW'(s_q.len);
                    s_d.msg_cnt  = s_q.msg_cnt + CW'(1);
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (rel_i && (s_q.msg_cnt != '0)) begin
            s_d.rd_ptr   = s_q.rd_ptr + AW'(rel_len);
            s_d.byte_cnt = s_d.byte_cnt - CW'(rel_len);
            s_d.msg_cnt  = s_d.msg_cnt - CW'(1);
        end
        if (op_enter_i) begin
            we           = 1'b0;
            s_d.st       = ST_IDLE;
            s_d.busy     = 1'b0;
            s_d.wr_ptr   = s_q.wr_ptr;
            s_d.rd_ptr   = s_q.wr_ptr;
            s_d.byte_cnt = '0;
            s_d.msg_cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, frm: '0, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready_o   = (s_q.st == ST_IDLE);
    assign byte_count_o = 7'(s_q.byte_cnt);
    assign msg_count_o  = 7'(s_q.msg_cnt);
    assign rx_pending_o = (s_q.msg_cnt != '0);
    assign overrun_o    = s_q.ovr;
    assign rx_busy_o    = s_q.busy;

    // R6: the byte count never exceeds the buffer size
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.byte_cnt <= CW'(DEPTH));

    // R7: no message stored means no byte counted
    p_empty_consistent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.msg_cnt == '0) |-> (s_q.byte_cnt == '0));

    // R7: a release on an empty store leaves the start pointer unchanged
    p_release_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && (s_q.msg_cnt == '0) && !op_enter_i) |=> $stable(s_q.rd_ptr));

    // R10: ready is never offered while a frame is in progress
    p_ready_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> !rx_busy_o);

    // R6: a frame dropped for overrun adds no bytes
    p_overrun_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.ovr) && !$past(rel_i) && !$past(op_enter_i)) |-> $stable(s_q.byte_cnt));
endmodule

// File: tb/canrx_record_fifo_tb_top.sv
module canrx_record_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ext = 1'b0, in_rtr = 1'b0, in_err = 1'b0;
    logic [3:0]  in_dlc = '0;
    logic [28:0] in_id = '0;
    logic [63:0] in_data = '0;
    logic        rel = 1'b0, ovr_clr = 1'b0, op_enter = 1'b0;
    logic [3:0]  win_off = '0;
    logic        in_ready, rx_pending, overrun, rx_busy;
    logic [7:0]  win_data;
    logic [6:0]  byte_count, msg_count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    byte unsigned mq[$];
    int           mlen[$];
    bit           movr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    canrx_record_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .in_ext_i(in_ext), .in_rtr_i(in_rtr), .in_err_i(in_err), .in_dlc_i(in_dlc),
        .in_id_i(in_id), .in_data_i(in_data), .rel_i(rel), .ovr_clr_i(ovr_clr),
        .op_enter_i(op_enter), .win_off_i(win_off), .win_data_o(win_data),
        .byte_count_o(byte_count), .msg_count_o(msg_count), .rx_pending_o(rx_pending),
        .overrun_o(overrun), .rx_busy_o(rx_busy)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(bit ext, bit rtr, int dlc);
        return 3 + (ext ? 2 : 0) + (rtr ? 0 : dlc);
    endfunction

    function automatic byte unsigned exp_byte(bit ext, bit rtr, logic [3:0] dlc,
                                              logic [28:0] id, logic [63:0] d, int k);
        int hdr = ext ? 5 : 3;
        if (k == 0) return {ext, rtr, 2'b00, dlc};
        if (k >= hdr) return d[8*(k-hdr) +: 8];
        if (ext) begin
            if (k == 1) return id[28:21];
            if (k == 2) return id[20:13];
            if (k == 3) return id[12:5];
            return {id[4:0], 3'b000};
        end
        if (k == 1) return id[10:3];
        return {id[2:0], 5'b00000};
    endfunction

    task automatic check_counts(string req);
        chk(req, 32'(byte_count), 32'(mq.size()));
        chk(req, 32'(msg_count), 32'(mlen.size()));
        chk("R8", 32'(rx_pending), 32'(mlen.size() != 0));
        chk(req, 32'(overrun), 32'(movr));
    endtask

    task automatic send(string req, bit ext, bit rtr, bit err, logic [3:0] dlc,
                        logic [28:0] id, logic [63:0] d);
        int cyc = 0;
        int exp_cyc = 1;
        @(negedge clk);
        in_valid = 1'b1; in_ext = ext; in_rtr = rtr; in_err = err;
        in_dlc = dlc; in_id = id; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", {30'd0, rx_busy, in_ready}, 32'h2);
        while (!in_ready) begin
            @(negedge clk);
            cyc++;
        end
        if (!(err || dlc > 8)) begin
            int len = exp_len(ext, rtr, dlc);
            if (mq.size() + len > DEPTH) begin
                movr = 1'b1;
            end else begin
                for (int k = 0; k < len; k++) mq.push_back(exp_byte(ext, rtr, dlc, id, d, k));
                mlen.push_back(len);
                exp_cyc = 1 + len;
            end
        end
        chk("R10", 32'(cyc), 32'(exp_cyc));
        chk("R10", 32'(rx_busy), 32'd0);
        check_counts(req);
    endtask

    task automatic release_one(string req);
        @(negedge clk);
        rel = 1'b1;
        @(negedge clk);
        rel = 1'b0;
        if (mlen.size() > 0) begin
            int len = mlen.pop_front();
            for (int k = 0; k < len; k++) void'(mq.pop_front());
        end
        check_counts(req);
    endtask

    task automatic check_window(string req);
        for (int k = 0; k < 13; k++) begin
            if (k < mq.size()) begin
                win_off = 4'(k);
                #1;
                chk(req, 32'(win_data), 32'(mq[k]));
            end
        end
    endtask

    task automatic pulse_ovr_clr();
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        movr = 1'b0;
        chk("R6", 32'(overrun), 32'd0);
    endtask

    task automatic pulse_op_enter();
        @(negedge clk); op_enter = 1'b1;
        @(negedge clk); op_enter = 1'b0;
        mq.delete();
        mlen.delete();
        check_counts("R11");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int unsigned sd;
        sd = $urandom(32'd19088743);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {25'd0, byte_count}, 32'd0);
        chk("R1", {25'd0, msg_count}, 32'd0);
        chk("R1", {28'd0, overrun, rx_pending, rx_busy, in_ready}, 32'h1);

        // R2 extended record layout
        send("R2", 1, 0, 0, 4'd3, 29'h1ABCDE12, 64'h00000000_00C3B2A1);
        check_window("R2");
        release_one("R7");
        // R3 standard record layout
        send("R3", 0, 0, 0, 4'd8, 29'h000005A5, 64'h8877665544332211);
        check_window("R3");
        release_one("R7");
        // R4 remote frames carry no data bytes
        send("R4", 1, 1, 0, 4'd5, 29'h0F0F0F0F, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R4", 32'(byte_count), 32'd5);
        send("R4", 0, 1, 0, 4'd7, 29'h00000123, 64'h1);
        check_window("R4");
        release_one("R4");
        release_one("R4");
        // R5 rejected frames
        send("R5", 0, 0, 0, 4'd9, 29'h7FF, 64'h55);
        send("R5", 1, 0, 1, 4'd2, 29'h1234, 64'h66);
        // R7 release with nothing stored
        release_one("R7");
        // R6 fill to overrun, then a small record still fits
        for (int i = 0; i < 5; i++) send("R6", 0, 0, 0, 4'd8, 29'(i * 37), {8{8'(i + 1)}});
        send("R6", 0, 0, 0, 4'd8, 29'h3FF, 64'hDEAD_BEEF_0BAD_F00D);
        chk("R6", 32'(overrun), 32'd1);
        send("R6", 1, 1, 0, 4'd0, 29'h1555_5555, 64'h0);
        check_window("R9");
        pulse_ovr_clr();
        // R11 operating mode entry empties the store
        pulse_op_enter();

        // random traffic
        for (int it = 0; it < 600; it++) begin
            int unsigned r = $urandom_range(0, 99);
            if (r < 50) begin
                logic [3:0] dl = 4'($urandom_range(0, 9));
                send("R2", 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
                     ($urandom_range(0, 15) == 0), dl, 29'($urandom()),
                     {$urandom(), $urandom()});
            end else if (r < 85) begin
                release_one("R7");
            end else if (r < 96) begin
                check_window("R9");
            end else if (r < 99) begin
                pulse_ovr_clr();
            end else begin
                pulse_op_enter();
            end
        end
        while (mlen.size() > 0) release_one("R7");
        check_counts("R8");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule